// File: doc/BRIEF.md
# Noise-Shaped PWM Audio Modulator

This block turns a stream of signed 24-bit audio samples into an 8-bit pulse-width value and drives a pair of class-D style output pins with it. A free-running 8-bit counter sets a PWM period of 256 clock cycles. Once per period a second-order error-feedback loop of two cascaded integrators takes one step. Each step quantises the loop state to the next duty value and feeds the quantisation error back. The audio sample is held for four PWM periods, so the loop oversamples the audio by four. Most of the requantisation noise is pushed above the audio band, where the output filter removes it.

The surrounding system supplies samples on request. The block raises a one-cycle request in the last cycle of every fourth PWM period and captures `sample_in` at the end of that cycle. A mode input selects how the two pins encode the signal. In anti-phase drive the second pin is the complement of the first. In in-phase drive both pins rise together at the start of each period: the first stays high for `duty` cycles, the second for `256 - duty` cycles, and the signal is carried by the difference of the two widths.

Top module: `sdm_pwm_top`

## Requirements
- R1: While reset is held and in the cycle after it is released, `duty_out` is 128, `sample_req` is low, the drive mode is anti-phase and the counter is at 0, so `pwm_a` is high and `pwm_b` is low.
- R2: Every PWM period is 256 clock cycles. Within it, `pwm_a` is high exactly while the period count (0 to 255) is below `duty_out`, so a duty of 0 keeps `pwm_a` low for the whole period.
- R3: `duty_out` changes only on the clock edge where the period count wraps from 255 to 0. It holds one value for a whole period.
- R4: `sample_req` is high for exactly one cycle, in count 255 of every fourth period (periods 3, 7, 11, ... counted from reset), and is low in every other cycle. `sample_in` is captured at the end of that cycle. The step taken on that same edge still uses the previous sample, and the captured sample feeds the next four steps. The sample held after reset is 0.
- R5: At each wrap the loop computes y = clamp(floor(I2 / 2^16) + 128, 0, 255) and f = (y - 128) * 2^16. It then updates I1 := sat(I1 + x - f) and I2 := sat(I2 + I1 - 2f), with the old I1 on the right of both updates. The value y becomes `duty_out` for the next period. I1 and I2 start at 0.
- R6: With all-zero input the duty stays at 128 in every period.
- R7: For a constant input x, the sum of (duty - 128) over 64 consecutive settled periods is within 3 of 64 * x / 2^16.
- R8: The integrators saturate at the limits of a 30-bit signed range and never wrap. With a full-scale positive input the duty settles at 255 and stays there, and with full-scale negative input it settles at 0 and stays there.
- R9: In in-phase drive (mode input 1), `pwm_b` is high exactly while the count is below 256 - `duty_out`. Both pins are therefore high in count 0.
- R10: In anti-phase drive (mode input 0), `pwm_b` is the inverse of `pwm_a` in every cycle.
- R11: The mode input is sampled only on the wrap edge. A change in the middle of a period leaves that period's encoding unchanged, and the new encoding applies from the next period on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one PWM count per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_mode | input | 1 | Pin encoding select: 0 anti-phase, 1 in-phase |
| sample_in | input | 24 | Signed audio sample, captured when `sample_req` is high |
| sample_req | output | 1 | One-cycle request for the next sample, once per four periods |
| duty_out | output | 8 | Duty value in force for the current PWM period |
| pwm_a | output | 1 | First output pin, high for `duty_out` cycles per period |
| pwm_b | output | 1 | Second output pin, encoding set by the latched mode |

## Verification
The loop is driven with four kinds of input. Silence shows that an idle modulator holds exact midscale. Constant half-step and fractional negative values are used to check that the duty's long-run mean follows sub-LSB input levels, which plain truncation could not produce. A ramp that changes every request is compared step by step with an independent model of the update equations; it catches an off-by-one in the sample timing, the feedback gain and the floor rounding. Full-scale positive and negative inputs separate saturating integrators from wrapping ones. Both pin encodings, and a mode change in the middle of a period, are checked cycle by cycle against the duty in force.

// File: rtl/sdm_pwm_pkg.sv
// Shared types for the noise-shaped PWM modulator.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package sdm_pwm_pkg;

    // Encoding of the two output pins.
    typedef enum logic {
        DRIVE_ANTI = 1'b0,
        DRIVE_INPH = 1'b1
    } drive_mode_e;

    // Strobes produced by the period timer.
    typedef struct packed {
        logic wrap;       // last cycle of a PWM period
        logic frame_end;  // last cycle of the last period in an oversampling frame
    } tick_t;

endpackage

// File: rtl/sdm_pwm_timer.sv
// Period timer: a free-running DUTY_W-bit count and an oversampling frame
// counter. It emits a wrap strobe in the last cycle of each period and a frame
// strobe in the last cycle of every OSR-th period.
// Assumes: OSR >= 1.
module sdm_pwm_timer
    import sdm_pwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int OSR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] cnt,
    output tick_t             tick
);
    localparam int OSR_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};
    localparam logic [OSR_W-1:0]  FRM_MAX = OSR_W'(OSR - 1);

    logic [OSR_W-1:0] frame;

    // Count clock cycles within a period and let the count wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Count periods within an oversampling frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           frame <= '0;
        else if (tick.wrap)   frame <= (frame == FRM_MAX) ? '0 : frame + 1'b1;
    end

    // Decode the period and frame boundary strobes.
    always_comb begin
        tick.wrap      = (cnt == CNT_MAX);
        tick.frame_end = tick.wrap && (frame == FRM_MAX);
    end
endmodule

// File: rtl/sdm_pwm_loop.sv
// Second-order error-feedback loop: two saturating integrators followed by a
// clamping quantiser that keeps the top DUTY_W bits. It takes one step per
// 'step' strobe, and 'load' captures a new input sample at the same edge. The
// step on that edge still uses the previous sample.
// Assumes: SAMPLE_W > DUTY_W and ACC_W >= SAMPLE_W + 4.
module sdm_pwm_loop #(
    parameter int SAMPLE_W = 24,
    parameter int DUTY_W   = 8,
    parameter int ACC_W    = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic [DUTY_W-1:0]          duty_q
);
    localparam int SHIFT = SAMPLE_W - DUTY_W;
    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [ACC_W-1:0] MID_A  = ACC_W'(2 ** (DUTY_W - 1));
    localparam logic signed [ACC_W-1:0] DMAX_A = ACC_W'(2 ** DUTY_W - 1);
    localparam logic signed [SUM_W-1:0] MID_S  = SUM_W'(2 ** (DUTY_W - 1));
    localparam logic signed [SUM_W-1:0] MAX_S  =
        {{(SUM_W - ACC_W + 1){1'b0}}, {(ACC_W - 1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MIN_S  =
        {{(SUM_W - ACC_W + 1){1'b1}}, {(ACC_W - 1){1'b0}}};
    localparam logic [DUTY_W-1:0] DUTY_MID = DUTY_W'(2 ** (DUTY_W - 1));

    logic signed [SAMPLE_W-1:0] x_q;
    logic signed [ACC_W-1:0]    i1_q, i2_q, q_raw;
    logic signed [SUM_W-1:0]    x_ext, i1_ext, i2_ext, y_ext, fb, sum1, sum2;
    logic [DUTY_W-1:0]          y;

    // Clamp a wide sum into the integrator range.
    function automatic logic signed [ACC_W-1:0] sat(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] c;
        if (v > MAX_S)      c = MAX_S;
        else if (v < MIN_S) c = MIN_S;
        else                c = v;
        return c[ACC_W-1:0];
    endfunction

    // Hold the current audio sample between requests.
    always_ff @(posedge clk) begin
        if (!rst_n)    x_q <= '0;
        else if (load) x_q <= sample_in;
    end

    // Quantise the second integrator to a clamped duty value.
    always_comb begin
        q_raw = (i2_q >>> SHIFT) + MID_A;
        if (q_raw < 0)           y = '0;
        else if (q_raw > DMAX_A) y = DMAX_A[DUTY_W-1:0];
        else                     y = q_raw[DUTY_W-1:0];
    end

    // Form the feedback value and the next integrator sums.
    always_comb begin
        x_ext  = {{(SUM_W - SAMPLE_W){x_q[SAMPLE_W-1]}}, x_q};
        i1_ext = {{(SUM_W - ACC_W){i1_q[ACC_W-1]}}, i1_q};
        i2_ext = {{(SUM_W - ACC_W){i2_q[ACC_W-1]}}, i2_q};
        y_ext  = {{(SUM_W - DUTY_W){1'b0}}, y};
        fb     = (y_ext - MID_S) <<< SHIFT;
        sum1   = i1_ext + x_ext - fb;
        sum2   = i2_ext + i1_ext - (fb <<< 1);
    end

    // Advance both integrators and publish the duty once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i1_q   <= '0;
            i2_q   <= '0;
            duty_q <= DUTY_MID;
        end else if (step) begin
            i1_q   <= sat(sum1);
            i2_q   <= sat(sum2);
            duty_q <= y;
        end
    end
endmodule

// File: rtl/sdm_pwm_drive.sv
// Pin driver: two mark-width comparators against the period count. Leg 0
// uses the duty as its width and leg 1 uses its complement width. The latched
// mode picks whether pin B is leg 1 (in-phase) or the inverse of pin A
// (anti-phase). The mode is latched only at the period wrap.
// Assumes: cnt and duty come from registers, so the pins are glitch-free.
module sdm_pwm_drive
    import sdm_pwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  drive_mode_e       mode_in,
    input  logic [DUTY_W-1:0] cnt,
    input  logic [DUTY_W-1:0] duty,
    output drive_mode_e       mode_q,
    output logic              pin_a,
    output logic              pin_b
);
    localparam logic [DUTY_W:0] FULL = {1'b1, {DUTY_W{1'b0}}};

    logic [DUTY_W:0] width [2];
    logic [1:0]      leg;

    assign width[0] = {1'b0, duty};
    assign width[1] = FULL - {1'b0, duty};

    // One comparator per output leg.
    for (genvar g = 0; g < 2; g++) begin : g_leg
        assign leg[g] = ({1'b0, cnt} < width[g]);
    end

    // Take a new pin encoding only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= DRIVE_ANTI;
        else if (wrap) mode_q <= mode_in;
    end

    // Map the legs onto the two pins.
    always_comb begin
        pin_a = leg[0];
        pin_b = (mode_q == DRIVE_INPH) ? leg[1] : ~leg[0];
    end
endmodule

// File: rtl/sdm_pwm_top.sv
// Noise-shaped PWM audio modulator top. It wires the period timer, the
// two-integrator loop and the pin driver together. A sample is requested in
// the last cycle of every OSR-th period and captured at the end of that cycle.
// Assumes: the sample source presents sample_in in the cycle sample_req is high.
module sdm_pwm_top
    import sdm_pwm_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int DUTY_W   = 8,
    parameter int OSR      = 4,
    parameter int ACC_W    = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       drive_mode,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic                       sample_req,
    output logic [DUTY_W-1:0]          duty_out,
    output logic                       pwm_a,
    output logic                       pwm_b
);
    logic [DUTY_W-1:0] pwm_cnt;
    tick_t             tick;
    drive_mode_e       mode_q;

    sdm_pwm_timer #(.DUTY_W(DUTY_W), .OSR(OSR)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (pwm_cnt),
        .tick (tick)
    );

    sdm_pwm_loop #(.SAMPLE_W(SAMPLE_W), .DUTY_W(DUTY_W), .ACC_W(ACC_W)) loop_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick.wrap),
        .load     (tick.frame_end),
        .sample_in(sample_in),
        .duty_q   (duty_out)
    );

    sdm_pwm_drive #(.DUTY_W(DUTY_W)) drive_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (tick.wrap),
        .mode_in(drive_mode_e'(drive_mode)),
        .cnt    (pwm_cnt),
        .duty   (duty_out),
        .mode_q (mode_q),
        .pin_a  (pwm_a),
        .pin_b  (pwm_b)
    );

    // Request the next sample at the end of each oversampling frame.
    assign sample_req = tick.frame_end;
endmodule

// File: rtl/sdm_pwm_chk.sv
// Property checker for the noise-shaped PWM modulator, bound to the top.
// Assumes: cnt is the period count and mode_q the latched pin encoding.
module sdm_pwm_chk #(
    parameter int DUTY_W = 8,
    parameter int OSR    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DUTY_W-1:0] cnt,
    input logic              mode_q,
    input logic [DUTY_W-1:0] duty,
    input logic              pin_a,
    input logic              pin_b,
    input logic              req
);
    localparam int FRAME = OSR * (2 ** DUTY_W);
    localparam int GAP_W = $clog2(FRAME) + 1;

    logic [GAP_W-1:0] gap;

    // Count cycles since reset or since the last sample request.
    always_ff @(posedge clk) begin
        if (!rst_n)   gap <= '0;
        else if (req) gap <= '0;
        else          gap <= gap + 1'b1;
    end

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt != '0) |-> $stable(duty)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (cnt == '1) |=> (cnt == '0)); // R2
    AST_ZERO_MARK: assert property (@(posedge clk) disable iff (!rst_n) (duty == '0) |-> !pin_a); // R2
    AST_REQ_SLOT: assert property (@(posedge clk) disable iff (!rst_n) req |-> (cnt == '1)); // R4
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n) req |-> (gap == GAP_W'(FRAME - 1))); // R4
    AST_ANTI_PAIR: assert property (@(posedge clk) disable iff (!rst_n) !mode_q |-> (pin_b != pin_a)); // R10
    AST_INPH_RISE: assert property (@(posedge clk) disable iff (!rst_n) (mode_q && cnt == '0 && duty != '0) |-> (pin_a && pin_b)); // R9
endmodule

bind sdm_pwm_top sdm_pwm_chk #(.DUTY_W(DUTY_W), .OSR(OSR)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (pwm_cnt),
    .mode_q(mode_q),
    .duty  (duty_out),
    .pin_a (pwm_a),
    .pin_b (pwm_b),
    .req   (sample_req)
);

// File: tb/sdm_pwm_tb.sv
// Directed bench for the noise-shaped PWM modulator: one task per scenario.
module sdm_pwm_top_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              drive_mode = 1'b0;
    logic signed [23:0] sample_in = '0;
    logic              sample_req;
    logic [7:0]        duty_out;
    logic              pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Independent model state (R5 equations).
    longint i1_m, i2_m, x_m, duty_m;
    bit     mode_e;
    int     per;
    longint feed_val, feed_step;
    bit     acc_on;
    longint acc_sum;

    always #2 clk = ~clk;

    sdm_pwm_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_mode(drive_mode),
        .sample_in (sample_in),
        .sample_req(sample_req),
        .duty_out  (duty_out),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint quant(input longint v);
        longint q = (v >>> 16) + 128;
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    function automatic longint satm(input longint v);
        if (v > 536870911) return 536870911;
        if (v < -536870912) return -536870912;
        return v;
    endfunction

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        drive_mode = mode;
        sample_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        i1_m = 0; i2_m = 0; x_m = 0; duty_m = 128;
        mode_e = 1'b0; per = 0; acc_on = 1'b0; acc_sum = 0;
    endtask

    // Run one PWM period from count 0, checking pins, duty and requests.
    task automatic run_period(input int switch_at, input bit new_mode, input string b_tag);
        int bad_a = 0, bad_b = 0, bad_req = 0, bad_hold = 0;
        longint d0 = duty_out;
        check(d0 == duty_m, "R5", "period duty vs model", d0, duty_m);
        if (acc_on) acc_sum += d0 - 128;
        for (int k = 0; k < 256; k++) begin
            bit ea, eb, er;
            ea = (k < d0);
            eb = mode_e ? (k < 256 - d0) : !ea;
            er = (k == 255) && (per % 4 == 3);
            if (pwm_a != ea) bad_a++;
            if (pwm_b != eb) bad_b++;
            if (sample_req != er) bad_req++;
            if (duty_out != d0) bad_hold++;
            if (k == switch_at) drive_mode = new_mode;
            if (k == 255) begin
                longint y, f, n1, n2;
                y = quant(i2_m);
                f = (y - 128) * 65536;
                n1 = satm(i1_m + x_m - f);
                n2 = satm(i2_m + i1_m - 2 * f);
                i1_m = n1; i2_m = n2; duty_m = y;
                mode_e = drive_mode;
                if (sample_req) begin
                    sample_in = feed_val[23:0];
                    x_m = feed_val;
                    feed_val += feed_step;
                end
            end
            @(negedge clk);
        end
        per++;
        check(bad_a == 0, "R2", "pwm_a mismatched cycles", bad_a, 0);
        check(bad_b == 0, b_tag, "pwm_b mismatched cycles", bad_b, 0);
        check(bad_req == 0, "R4", "sample_req mismatched cycles", bad_req, 0);
        check(bad_hold == 0, "R3", "duty changed inside period", bad_hold, 0);
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        // R1: state right after release, before the first mode latch
        check(duty_out == 128, "R1", "duty after reset", duty_out, 128);
        check(sample_req == 0, "R1", "sample_req after reset", sample_req, 0);
        check(pwm_a == 1, "R1", "pwm_a at count 0", pwm_a, 1);
        check(pwm_b == 0, "R1", "pwm_b anti-phase after reset", pwm_b, 0);
        feed_val = 0; feed_step = 0;
        run_period(-1, 1'b0, "R10");
    endtask

    task automatic t_zero();
        int off = 0;
        do_reset(1'b0);
        feed_val = 0; feed_step = 0;
        for (int p = 0; p < 16; p++) begin
            if (duty_out != 128) off++;
            run_period(-1, 1'b0, "R10");
        end
        check(off == 0, "R6", "periods away from midscale", off, 0);
    endtask

    task automatic t_dc(input longint x, input longint exp_sum);
        do_reset(1'b0);
        feed_val = x; feed_step = 0;
        for (int p = 0; p < 16; p++) run_period(-1, 1'b0, "R10");
        acc_on = 1'b1;
        for (int p = 0; p < 64; p++) run_period(-1, 1'b0, "R10");
        acc_on = 1'b0;
        check(acc_sum >= exp_sum - 3 && acc_sum <= exp_sum + 3, "R7",
              "sum of duty offsets", acc_sum, exp_sum);
    endtask

    task automatic t_ramp();
        do_reset(1'b0);
        feed_val = -64'sh300000; feed_step = 64'sh60000;
        for (int p = 0; p < 64; p++) run_period(-1, 1'b0, "R10");
    endtask

    task automatic t_overload(input longint x, input longint pin_val);
        int off = 0;
        do_reset(1'b0);
        feed_val = x; feed_step = 0;
        for (int p = 0; p < 48; p++) begin
            if (p >= 24 && duty_out != pin_val) off++;
            run_period(-1, 1'b0, "R10");
        end
        check(off == 0, "R8", "periods off the clamp value", off, 0);
    endtask

    task automatic t_inphase();
        do_reset(1'b1);
        feed_val = 64'sh300000; feed_step = 0;
        run_period(-1, 1'b0, "R10");
        for (int p = 0; p < 12; p++) begin
            check(mode_e == 1'b1, "R9", "in-phase latched", mode_e, 1);
            run_period(-1, 1'b0, "R9");
        end
    endtask

    task automatic t_switch();
        do_reset(1'b0);
        feed_val = -64'sh280000; feed_step = 0;
        run_period(-1, 1'b0, "R10");
        run_period(-1, 1'b0, "R10");
        // R11: change mid-period, encoding must hold until the wrap
        run_period(100, 1'b1, "R11");
        check(mode_e == 1'b1, "R11", "mode taken at wrap", mode_e, 1);
        run_period(-1, 1'b0, "R11");
        run_period(37, 1'b0, "R11");
        run_period(-1, 1'b0, "R11");
    endtask

    initial begin
        t_reset();
        t_zero();
        t_dc(64'sh8000, 32);
        t_dc(-64'sh24000, -144);
        t_ramp();
        t_overload(64'sh7FFFFF, 255);
        t_overload(-64'sh800000, 0);
        t_inphase();
        t_switch();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule